// File: doc/BRIEF.md
# Indexed Palette RAM Write Port

This block is a byte-wide register front end to a colour lookup table. The table has 256 entries, and each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. To load the table, a host writes a starting index. It then streams component bytes through one data register, always in the order red, green, blue. The block collects each triple in staging registers and writes the whole entry into the table when the blue byte arrives. After each blue byte the index steps forward, so a run of consecutive entries needs only one index write.

A second index register sets up reads. Successive reads of the data register return red, green and blue of the entry at the read index, and the read index then steps forward. A pixel mask register is ANDed with each incoming pixel code before the table is looked up. The look-up port turns an 8-bit pixel into a 24-bit colour with one cycle of latency. A precision input selects full 8-bit components. When it is low, the two low bits of each component on the look-up output are forced to zero.

Top module: `clut_port`

## Requirements
- R1: After reset, the write index, the read index and the pixel mask all read back as 0, and both byte sequences start at red.
- R2: Register select `bus_addr` decodes as follows: 0 is the write index, 1 is the data port, 2 is the pixel mask and 3 is the read index. Reads of 0, 2 and 3 return the current register value.
- R3: Data-port writes supply red, then green, then blue. The table entry changes only on the blue write. The red and green bytes are held until then, so a look-up of that entry still returns the old colour while the triple is incomplete.
- R4: After each blue write the write index increments by one, and it wraps from 255 to 0.
- R5: A write to either index register returns both the write sequence and the read sequence to red. Partial bytes from before that write are never committed on their own.
- R6: Successive data-port reads return red, green, then blue of the entry at the read index. After the blue read the read index increments, wrapping from 255 to 0.
- R7: The pixel mask is written and read back through register 2.
- R8: `rgb_out` equals the entry at (`pix_in` AND mask), packed as red in bits 23:16, green in 15:8 and blue in 7:0. It appears on the clock edge after `pix_in` is sampled.
- R9: When `full_prec` is 0, bits 1:0 of each component on `rgb_out` are 0 and bits 7:2 are the stored bits 7:2. Data-port reads always return the stored byte unchanged.
- R10: When `bus_wr` and `bus_rd` are both high in the same cycle, the write takes effect and the read is ignored. The read sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the selected register (combinational) |
| full_prec | input | 1 | 1 selects full 8-bit components on the look-up output |
| pix_in | input | 8 | Pixel code to look up |
| rgb_out | output | 24 | Registered colour for the previous cycle's pixel |

## Verification
The bench targets several corner cases:
- An incomplete triple followed by a look-up. A design that commits early would show a half-written colour.
- A restart of the write sequence by a read-index write. A design that does not restart would place the new bytes in shifted components.
- Write streams and read streams that cross entry 255. A wrong wrap lands on entry 256's alias or stalls.
- A simultaneous read and write. A design that lets the read through would skip the red byte on the next read.
- Masked pixel codes and reduced precision. These expose an unmasked index, or trimming applied to the wrong path.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CLUT_CW = 8;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  localparam logic [1:0] SEL_WIDX = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
  localparam logic [1:0] SEL_RIDX = 2'd3;

  function automatic phase_t phase_next(input phase_t p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  function automatic logic last_of_triple(input phase_t p);
    return p == PH_BLU;
  endfunction
endpackage

// File: rtl/clut_wr_ctl.sv
module clut_wr_ctl
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             restart,
  input  logic             data_we,
  input  logic [CW-1:0]    data,
  output logic [IDX_W-1:0] wr_idx,
  output phase_t           wr_phase,
  output logic             commit,
  output logic [3*CW-1:0]  commit_word
);
  logic [CW-1:0] stg_r, stg_g;

  assign commit      = data_we && last_of_triple(wr_phase);
  assign commit_word = {stg_r, stg_g, data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx   <= '0;
      wr_phase <= PH_RED;
      stg_r    <= '0;
      stg_g    <= '0;
    end else if (idx_load) begin
      wr_idx   <= idx_val;
      wr_phase <= PH_RED;
    end else if (restart) begin
      wr_phase <= PH_RED;
    end else if (data_we) begin
      case (wr_phase)
        PH_RED:  stg_r <= data;
        PH_GRN:  stg_g <= data;
        default: wr_idx <= wr_idx + 1'b1;
      endcase
      wr_phase <= phase_next(wr_phase);
    end
  end

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !idx_load && !restart) |=> wr_idx == $past(wr_idx) + 1'b1);

  p_phase_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_load || restart) |=> wr_phase == PH_RED);

  p_red_then_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && wr_phase == PH_RED && !idx_load && !restart) |=> wr_phase == PH_GRN);
endmodule

// File: rtl/clut_rd_ctl.sv
module clut_rd_ctl
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             restart,
  input  logic             data_re,
  output logic [IDX_W-1:0] rd_idx,
  output phase_t           rd_phase
);
  logic rd_wrap_ev;
  assign rd_wrap_ev = data_re && last_of_triple(rd_phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx   <= '0;
      rd_phase <= PH_RED;
    end else if (idx_load) begin
      rd_idx   <= idx_val;
      rd_phase <= PH_RED;
    end else if (restart) begin
      rd_phase <= PH_RED;
    end else if (data_re) begin
      if (rd_wrap_ev) rd_idx <= rd_idx + 1'b1;
      rd_phase <= phase_next(rd_phase);
    end
  end

  p_rd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wrap_ev && !idx_load && !restart) |=> rd_idx == $past(rd_idx) + 1'b1);

  p_rd_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_load || restart) |=> rd_phase == PH_RED);
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W = 8,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [3*CW-1:0]  wword,
  input  logic [IDX_W-1:0] raddr,
  output logic [3*CW-1:0]  rword,
  input  logic [IDX_W-1:0] lut_addr,
  input  logic             full_prec,
  output logic [3*CW-1:0]  lut_word
);
  localparam int DEPTH = 1 << IDX_W;

  logic [3*CW-1:0] mem [DEPTH];
  logic [3*CW-1:0] lut_raw, lut_trim;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  assign rword   = mem[raddr];
  assign lut_raw = mem[lut_addr];

  for (genvar c = 0; c < 3; c++) begin : g_comp
    assign lut_trim[c*CW +: CW] = full_prec ? lut_raw[c*CW +: CW]
                                            : {lut_raw[c*CW+2 +: CW-2], 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lut_word <= '0;
    else        lut_word <= lut_trim;
  end

  p_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !full_prec |=> (lut_word[1:0] == 2'b00 && lut_word[CW +: 2] == 2'b00
                    && lut_word[2*CW +: 2] == 2'b00));
endmodule

// File: rtl/clut_port.sv
module clut_port
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CW    = CLUT_CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  input  logic            full_prec,
  input  logic [IDX_W-1:0] pix_in,
  output logic [3*CW-1:0] rgb_out
);
  logic             widx_ld, ridx_ld, any_idx_ld, data_we, data_re, mask_we;
  logic [IDX_W-1:0] wr_idx, rd_idx, mask_q, lut_addr;
  phase_t           wr_phase, rd_phase;
  logic             commit;
  logic [3*CW-1:0]  commit_word, rd_word;

  assign widx_ld    = bus_wr && bus_addr == SEL_WIDX;
  assign ridx_ld    = bus_wr && bus_addr == SEL_RIDX;
  assign any_idx_ld = widx_ld || ridx_ld;
  assign data_we    = bus_wr && bus_addr == SEL_DATA;
  assign mask_we    = bus_wr && bus_addr == SEL_MASK;
  assign data_re    = bus_rd && !bus_wr && bus_addr == SEL_DATA;
  assign lut_addr   = pix_in & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= bus_wdata[IDX_W-1:0];
  end

  clut_wr_ctl #(.IDX_W(IDX_W), .CW(CW)) u_wr (
    .clk(clk), .rst_n(rst_n), .idx_load(widx_ld), .idx_val(bus_wdata[IDX_W-1:0]),
    .restart(ridx_ld), .data_we(data_we), .data(bus_wdata), .wr_idx(wr_idx),
    .wr_phase(wr_phase), .commit(commit), .commit_word(commit_word));

  clut_rd_ctl #(.IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .idx_load(ridx_ld), .idx_val(bus_wdata[IDX_W-1:0]),
    .restart(widx_ld), .data_re(data_re), .rd_idx(rd_idx), .rd_phase(rd_phase));

  clut_store #(.IDX_W(IDX_W), .CW(CW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(commit), .waddr(wr_idx), .wword(commit_word),
    .raddr(rd_idx), .rword(rd_word), .lut_addr(lut_addr), .full_prec(full_prec),
    .lut_word(rgb_out));

  always_comb begin
    case (bus_addr)
      SEL_WIDX: bus_rdata = CW'(wr_idx);
      SEL_MASK: bus_rdata = CW'(mask_q);
      SEL_RIDX: bus_rdata = CW'(rd_idx);
      default: begin
        case (rd_phase)
          PH_RED:  bus_rdata = rd_word[2*CW +: CW];
          PH_GRN:  bus_rdata = rd_word[CW +: CW];
          default: bus_rdata = rd_word[0 +: CW];
        endcase
      end
    endcase
  end

  p_rd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd && bus_addr != SEL_WIDX && bus_addr != SEL_RIDX)
      |=> ($stable(rd_idx) && $stable(rd_phase)));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: tb/sim_clut_port.sv
module sim_clut_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        full_prec = 1'b1;
  logic [7:0]  pix_in = 8'd0;
  logic [23:0] rgb_out;

  always #4 clk = ~clk;

  clut_port u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .full_prec(full_prec), .pix_in(pix_in), .rgb_out(rgb_out));

  int vectors = 0, miscompares = 0;
  logic [7:0]  rq[$];  string rr[$];
  logic [23:0] lq[$];  string lr[$];
  logic        pix_flag = 1'b0, look_pend = 1'b0;
  logic [23:0] mdl [256];
  logic [7:0]  m_widx = 8'd0;

  function automatic logic [23:0] trim(input logic [23:0] v, input logic full);
    return full ? v : (v & 24'hFCFCFC);
  endfunction

  always @(negedge clk) begin
    if (look_pend && lq.size() > 0) begin
      logic [23:0] e; string t;
      e = lq.pop_front(); t = lr.pop_front(); vectors++;
      if (rgb_out !== e) begin
        miscompares++;
        $display("FAIL %s lookup: got %h expected %h", t, rgb_out, e);
      end
    end
    look_pend = pix_flag;
    if (bus_rd && !bus_wr && rq.size() > 0) begin
      logic [7:0] e; string t;
      e = rq.pop_front(); t = rr.pop_front(); vectors++;
      if (bus_rdata !== e) begin
        miscompares++;
        $display("FAIL %s read addr %0d: got %h expected %h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic drive(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; pix_flag = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    drive(1'b1, 1'b0, a, d);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string t);
    rq.push_back(e); rr.push_back(t);
    drive(1'b0, 1'b1, a, 8'd0);
  endtask

  task automatic set_widx(input logic [7:0] v);
    wr(2'd0, v); m_widx = v;
  endtask

  task automatic put(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    wr(2'd1, r); wr(2'd1, g); wr(2'd1, b);
    mdl[m_widx] = {r, g, b}; m_widx = m_widx + 8'd1;
  endtask

  task automatic look(input logic [7:0] p, input logic full, input logic [23:0] e, input string t);
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_rd = 1'b0; pix_in = p; full_prec = full; pix_flag = 1'b1;
    lq.push_back(e); lr.push_back(t);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 2'd0, 8'd0);
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset values of the registers
    rd_chk(2'd0, 8'h00, "R1");
    rd_chk(2'd3, 8'h00, "R1");
    rd_chk(2'd2, 8'h00, "R1");
    // R7 / R2: mask write and read back
    wr(2'd2, 8'hFF);
    rd_chk(2'd2, 8'hFF, "R7");
    // R3 / R8: one full triple, then look-up
    set_widx(8'd5);
    put(8'h11, 8'h22, 8'h33);
    look(8'd5, 1'b1, mdl[5], "R8");
    rd_chk(2'd0, 8'd6, "R4");
    // R3: a partial triple does not change the entry
    set_widx(8'd10);
    put(8'hA1, 8'hA2, 8'hA3);
    set_widx(8'd10);
    wr(2'd1, 8'h55); wr(2'd1, 8'h66);
    look(8'd10, 1'b1, 24'hA1A2A3, "R3");
    wr(2'd1, 8'h77); mdl[10] = 24'h556677; m_widx = 8'd11;
    look(8'd10, 1'b1, 24'h556677, "R3");
    // R5: a read-index write restarts the write sequence
    set_widx(8'd20);
    wr(2'd1, 8'h01); wr(2'd1, 8'h02);
    wr(2'd3, 8'd0);
    put(8'h31, 8'h32, 8'h33);
    look(8'd20, 1'b1, 24'h313233, "R5");
    // R4: streaming across the top of the table
    set_widx(8'd254);
    put(8'hC7, 8'h5B, 8'h3E);
    put(8'h44, 8'h45, 8'h46);
    put(8'h01, 8'h82, 8'hF3);
    rd_chk(2'd0, 8'd1, "R4");
    look(8'd255, 1'b1, 24'h444546, "R4");
    look(8'd0, 1'b1, 24'h0182F3, "R4");
    // R6: read stream wrapping from 255 to 0
    wr(2'd3, 8'd254);
    for (int k = 0; k < 3; k++) begin
      logic [23:0] v;
      v = mdl[8'(254 + k)];
      rd_chk(2'd1, v[23:16], "R6");
      rd_chk(2'd1, v[15:8], "R6");
      rd_chk(2'd1, v[7:0], "R6");
    end
    rd_chk(2'd3, 8'd1, "R6");
    // R5: a write-index write restarts the read sequence
    wr(2'd3, 8'd5);
    rd_chk(2'd1, 8'h11, "R5");
    set_widx(8'd6);
    rd_chk(2'd1, 8'h11, "R5");
    // R10: simultaneous write and read on the data port
    wr(2'd3, 8'd5);
    drive(1'b1, 1'b1, 2'd1, 8'h99);
    rd_chk(2'd1, 8'h11, "R10");
    wr(2'd1, 8'h9A); wr(2'd1, 8'h9B);
    mdl[6] = 24'h999A9B; m_widx = 8'd7;
    look(8'd6, 1'b1, 24'h999A9B, "R10");
    // R8: mask applied to the pixel code
    wr(2'd2, 8'h0F);
    look(8'hF5, 1'b1, mdl[5], "R8");
    look(8'h1A, 1'b1, mdl[10], "R8");
    // R9: reduced precision on the look-up path only
    wr(2'd2, 8'hFF);
    look(8'd254, 1'b0, trim(24'hC75B3E, 1'b0), "R9");
    look(8'd254, 1'b1, 24'hC75B3E, "R9");
    wr(2'd3, 8'd254);
    @(posedge clk); #2 full_prec = 1'b0; pix_flag = 1'b0;
    rd_chk(2'd1, 8'hC7, "R9");
    idle(); idle(); idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule